// File: doc/BRIEF.md
# Pseudo-SRAM Wake and Deep-Standby Sequencer

This block sits on the controller side of an asynchronous pseudo-SRAM and owns the device's control pins while the memory is being brought to a usable state. After reset (power-up) it holds chip select and the standby-mode pin high for a stabilization interval. It then issues a fixed number of dummy reads, each framed by its own chip-select low pulse, with output enable and write enable kept high so that nothing drives the data bus. Only after the last dummy read does it raise `ready`. From that point a separate bus cycle engine may run normal accesses.

While `ready` is high the host may ask for deep standby, a low-power state in which the memory does not keep its contents. The sequencer drops `ready` at once and keeps chip select high for one cycle. It then pulls the mode pin low, so that chip select is always high before the mode pin falls. A wake request in deep standby replays the full power-up sequence. Requests that arrive at the wrong time are stalled or have no effect. All intervals are parameters in nanoseconds and are turned into clock counts, always rounded up.

Top module: `psw_seq_top`

## Requirements
- R1: From reset, and from every accepted wake request, chip select, output enable, write enable, both byte selects and the mode pin are all high and `ready` is low for exactly WAIT_CYC = ceil(WAIT_NS/CLK_NS) cycles.
- R2: After the wait, exactly NREAD chip-select low pulses are produced. Each lasts RD_CYC = ceil(RD_NS/CLK_NS) cycles.
- R3: Chip select is high for exactly CSH_CYC = max(1, ceil(CSH_NS/CLK_NS)) cycles after each dummy read pulse, the last pulse included, before the next pulse or before `ready` rises.
- R4: Throughout the wait and the dummy reads, output enable and write enable stay high and the mode pin stays high.
- R5: `ready` rises exactly WAIT_CYC + NREAD*(RD_CYC+CSH_CYC) cycles after the sequence starts and stays high, with all pins high, until a standby request is accepted.
- R6: A standby request seen while `ready` is high drops `ready` on the next cycle. Chip select and mode are then both high for one cycle, and from the following cycle mode is low with chip select still high.
- R7: A standby request raised while `ready` is low does not alter the sequence. It is held off and accepted on the first cycle `ready` is high.
- R8: A wake request in deep standby starts the complete sequence of R1 to R5 again.
- R9: A wake request while `ready` is high has no effect on any pin or on `ready`. A standby request during deep standby has no effect either: the mode pin stays low.
- R10: Both byte selects are low during each dummy read pulse and high in every other cycle.
- R11: A synchronous reset asserted part-way through the sequence returns all pins high and `ready` low, and after release the full sequence runs from its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts the power-up sequence |
| stby_req | input | 1 | Host request to enter deep standby, level-held until accepted |
| wake_req | input | 1 | Host request to leave deep standby |
| ready | output | 1 | Memory is initialized and free for normal accesses |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lb_n | output | 1 | Memory lower byte select, active low |
| mem_ub_n | output | 1 | Memory upper byte select, active low |
| mem_mode | output | 1 | Memory standby-mode pin; low selects deep standby |

## Verification
All pins and `ready` are decoded from the registered state. Each result therefore appears one clock after the edge that takes the stimulus, and the bench numbers the cycles of a sequence from the first sample that shows the loaded wait state. For every cycle index k up to the ready point, the bench works out the expected pin vector arithmetically from the wait, pulse and gap lengths, and compares it on the falling edge. Standby entry is checked on the first and second falling edges after the accepting edge. The ignored-request cases are checked on every cycle for which the request is held.

// File: rtl/psw_pkg.sv
// Package: shared types and helpers for the pseudo-SRAM wake sequencer.
// Assumes all time arguments are in nanoseconds and the clock period is non-zero.
package psw_pkg;

    // Sequencer states; pins are decoded from these.
    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_RD_LO = 3'd1,
        ST_RD_HI = 3'd2,
        ST_READY = 3'd3,
        ST_ENTER = 3'd4,
        ST_DEEP  = 3'd5
    } psw_state_e;

    // Memory-side control pins, all but mode active low.
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic lb_n;
        logic ub_n;
        logic mode;
    } psw_pins_t;

    // Converts a minimum time to a cycle count, rounding up, with a floor.
    function automatic int unsigned cyc_ceil(input int unsigned ns,
                                             input int unsigned per,
                                             input int unsigned lo);
        int unsigned c;
        c = (ns + per - 1) / per;
        if (c < lo) c = lo;
        return c;
    endfunction

    // Largest of three counts, used to size the shared timer.
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/psw_timer.sv
// Module: down-counting interval timer shared by all timed phases.
// Assumes the caller loads (length - 1) on the cycle a phase starts; zero
// then marks the last cycle of that phase. Reset loads RST_VAL so the
// first phase after reset needs no explicit load.
module psw_timer #(
    parameter int unsigned CW      = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    // Counter: reset preset, explicit load, else count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag for the controlling state machine.
    assign zero = (cnt_q == '0);

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));                                   // R1
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));              // R2

endmodule

// File: rtl/psw_fsm.sv
// Module: phase sequencing for wait, dummy reads, ready and deep standby.
// Assumes the timer was preset by reset to WAIT_CYC-1, so reset lands in
// the wait phase with a full interval. Standby requests are taken only in
// ST_READY, and wake requests only in ST_DEEP.
module psw_fsm
    import psw_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 4,
    parameter int unsigned LOW_CYC  = 2,
    parameter int unsigned HIGH_CYC = 1,
    parameter int unsigned NREAD    = 3,
    parameter int unsigned CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_req,
    input  logic          wake_req,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output psw_state_e    state
);

    localparam int unsigned IW = (NREAD > 1) ? $clog2(NREAD) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NREAD - 1);

    psw_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    // Next-state, timer-load and read-index logic.
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_WAIT: begin
                if (tmr_zero) begin
                    state_d  = ST_RD_LO;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(LOW_CYC - 1);
                end
            end
            ST_RD_LO: begin
                if (tmr_zero) begin
                    state_d  = ST_RD_HI;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HIGH_CYC - 1);
                end
            end
            ST_RD_HI: begin
                if (tmr_zero) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_READY;
                    end else begin
                        state_d  = ST_RD_LO;
                        idx_d    = idx_q + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(LOW_CYC - 1);
                    end
                end
            end
            ST_READY: begin
                if (stby_req) state_d = ST_ENTER;
            end
            ST_ENTER: begin
                state_d = ST_DEEP;
            end
            ST_DEEP: begin
                if (wake_req) begin
                    state_d  = ST_WAIT;
                    idx_d    = '0;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(WAIT_CYC - 1);
                end
            end
            default: begin
                state_d = ST_WAIT;
                idx_d   = '0;
            end
        endcase
    end

    // State and read-index registers with synchronous reset to the wait phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state = state_q;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);                                                      // R2
    AST_WAKE_ONLY_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) != ST_WAIT && $past(rst_n))
        |-> ($past(state_q) == ST_DEEP && $past(wake_req)));                     // R8
    AST_ENTER_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |-> ($past(state_q) == ST_READY && $past(stby_req))); // R7

endmodule

// File: rtl/psw_pins.sv
// Module: decodes the sequencer state into memory control pins.
// Assumes pins are glitch-free because they follow a single registered
// state vector. The mode pin is low only in deep standby.
module psw_pins
    import psw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  psw_state_e state,
    output psw_pins_t  pins
);

    // Pin decode per phase; dummy reads select both bytes with reads only.
    always_comb begin
        pins = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                 lb_n: 1'b1, ub_n: 1'b1, mode: 1'b1};
        case (state)
            ST_RD_LO: begin
                pins.cs_n = 1'b0;
                pins.lb_n = 1'b0;
                pins.ub_n = 1'b0;
            end
            ST_DEEP: begin
                pins.mode = 1'b0;
            end
            default: ;
        endcase
    end

    AST_MODE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pins.mode) |-> (pins.cs_n && $past(pins.cs_n)));                  // R6
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.cs_n |-> (pins.oe_n && pins.we_n && pins.mode));                  // R4
    AST_NO_BYTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pins.cs_n |-> (pins.lb_n && pins.ub_n));                                // R10

endmodule

// File: rtl/psw_seq_top.sv
// Module: top of the pseudo-SRAM wake and deep-standby sequencer.
// Converts nanosecond minimums to clock counts (rounded up), ties the
// timer, phase machine and pin decode together, and raises ready once the
// dummy reads are done. Assumes the host holds stby_req until ready falls.
module psw_seq_top
    import psw_pkg::*;
#(
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned WAIT_NS = 200000,
    parameter int unsigned RD_NS   = 90,
    parameter int unsigned CSH_NS  = 10,
    parameter int unsigned NREAD   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_req,
    input  logic wake_req,
    output logic ready,
    output logic mem_cs_n,
    output logic mem_oe_n,
    output logic mem_we_n,
    output logic mem_lb_n,
    output logic mem_ub_n,
    output logic mem_mode
);

    localparam int unsigned WAIT_CYC = cyc_ceil(WAIT_NS, CLK_NS, 1);
    localparam int unsigned LOW_CYC  = cyc_ceil(RD_NS, CLK_NS, 1);
    localparam int unsigned HIGH_CYC = cyc_ceil(CSH_NS, CLK_NS, 1);
    localparam int unsigned CW       = $clog2(max3(WAIT_CYC, LOW_CYC, HIGH_CYC) + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    psw_state_e    state;
    psw_pins_t     pins;

    psw_timer #(
        .CW      (CW),
        .RST_VAL (WAIT_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    psw_fsm #(
        .WAIT_CYC (WAIT_CYC),
        .LOW_CYC  (LOW_CYC),
        .HIGH_CYC (HIGH_CYC),
        .NREAD    (NREAD),
        .CW       (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stby_req (stby_req),
        .wake_req (wake_req),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state    (state)
    );

    psw_pins u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .pins  (pins)
    );

    // Port mapping of the decoded pins and the ready flag.
    assign ready    = (state == ST_READY);
    assign mem_cs_n = pins.cs_n;
    assign mem_oe_n = pins.oe_n;
    assign mem_we_n = pins.we_n;
    assign mem_lb_n = pins.lb_n;
    assign mem_ub_n = pins.ub_n;
    assign mem_mode = pins.mode;

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && stby_req) |=> (!ready && mem_mode && mem_cs_n));              // R6
    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready) && $past(rst_n)) |-> $past(stby_req));                    // R7
    AST_READY_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(mem_cs_n) && mem_cs_n && mem_mode));            // R3
    AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !stby_req) |=> ready);                                         // R9

endmodule

// File: tb/psw_seq_top_tb_top.sv
// Bench: walks every cycle of each wake sequence and compares the pin
// vector with a value computed from the wait, pulse and gap lengths.
module psw_seq_top_tb_top;

    localparam int unsigned CLK_NS  = 10;
    localparam int unsigned WAIT_NS = 500;
    localparam int unsigned RD_NS   = 80;
    localparam int unsigned CSH_NS  = 25;
    localparam int unsigned NREAD   = 3;

    localparam int WAIT_C = (WAIT_NS + CLK_NS - 1) / CLK_NS;
    localparam int LOW_C  = (RD_NS + CLK_NS - 1) / CLK_NS;
    localparam int HIGH_C = ((CSH_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (CSH_NS + CLK_NS - 1) / CLK_NS;
    localparam int READY_K = WAIT_C + NREAD * (LOW_C + HIGH_C);

    // Vector order: cs_n oe_n we_n lb_n ub_n mode ready
    localparam logic [6:0] V_WAIT  = 7'b1111110;
    localparam logic [6:0] V_PULSE = 7'b0110010;
    localparam logic [6:0] V_READY = 7'b1111111;
    localparam logic [6:0] V_DEEP  = 7'b1111100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_req = 1'b0;
    logic wake_req = 1'b0;
    logic ready, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_mode;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    psw_seq_top #(
        .CLK_NS (CLK_NS), .WAIT_NS (WAIT_NS), .RD_NS (RD_NS),
        .CSH_NS (CSH_NS), .NREAD (NREAD)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .stby_req (stby_req), .wake_req (wake_req),
        .ready (ready), .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n), .mem_lb_n (mem_lb_n), .mem_ub_n (mem_ub_n),
        .mem_mode (mem_mode)
    );

    function automatic logic [6:0] obs();
        return {mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_mode, ready};
    endfunction

    // Expected vector at cycle index k of a wake sequence.
    function automatic logic [6:0] exp_at(input int k);
        int r;
        if (k < WAIT_C) return V_WAIT;
        if (k >= READY_K) return V_READY;
        r = (k - WAIT_C) % (LOW_C + HIGH_C);
        return (r < LOW_C) ? V_PULSE : V_WAIT;
    endfunction

    function automatic string tag_at(input int k);
        int r;
        if (k < WAIT_C) return "R1/R4";
        if (k >= READY_K) return "R5";
        r = (k - WAIT_C) % (LOW_C + HIGH_C);
        return (r < LOW_C) ? "R2/R4/R10" : "R3/R4/R10";
    endfunction

    task automatic check_vec(input string req, input logic [6:0] expv);
        logic [6:0] a;
        a = obs();
        n_checks++;
        if (a !== expv) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, a, expv);
        end
    endtask

    // Checks cycle indices 0..last; the caller stands at the k=0 sample.
    task automatic run_seq(input string what, input int last);
        for (int k = 0; k <= last; k++) begin
            if (k > 0) @(negedge clk);
            check_vec({what, " ", tag_at(k)}, exp_at(k));
        end
    endtask

    // Accepts standby from ready and checks the two entry cycles.
    task automatic enter_deep();
        stby_req = 1'b1;
        @(negedge clk);
        stby_req = 1'b0;
        check_vec("R6 entry cs first", V_WAIT);
        @(negedge clk);
        check_vec("R6 mode low", V_DEEP);
    endtask

    task automatic start_wake();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state (R1)
        repeat (4) @(negedge clk);
        check_vec("R1 reset", V_WAIT);
        rst_n = 1'b1;
        run_seq("power-up", READY_K);

        // Wake request in ready ignored (R9)
        wake_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_vec("R9 wake in ready", V_READY);
        end
        wake_req = 1'b0;

        // Standby entry ordering (R6), then standby request in deep ignored (R9)
        enter_deep();
        stby_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_vec("R9 standby in deep", V_DEEP);
        end
        stby_req = 1'b0;

        // Full replay on wake (R8)
        start_wake();
        run_seq("R8 wake", READY_K);

        // Stalled standby request (R7)
        enter_deep();
        start_wake();
        stby_req = 1'b1;
        run_seq("R7 stalled", READY_K);
        @(negedge clk);
        stby_req = 1'b0;
        check_vec("R7 accepted at ready", V_WAIT);
        @(negedge clk);
        check_vec("R7 then deep", V_DEEP);

        // Reset in the middle of a dummy read (R11)
        start_wake();
        run_seq("R11 pre-reset", WAIT_C + LOW_C + 2);
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R11 in reset", V_WAIT);
        @(negedge clk);
        rst_n = 1'b1;
        run_seq("R11 restart", READY_K);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule